// File: doc/BRIEF.md
# Host-Register to AXI4-Lite Single-Word Bridge

This block gives a host that only has a narrow 16-bit register bus a way to run single 32-bit read and write transfers on an AXI4-Lite master port. The host sees eight 16-bit registers. It loads a 32-bit target address and, for writes, 32-bit write data as low and high halves. It then writes a command code into the control register, which starts exactly one AXI transfer. The host polls the status register for a sticky outcome event: completion, error or timeout. Read results come back as two 16-bit halves.

The control register also carries one enable per event. An event whose enable is clear is never recorded, but the transfer still runs and ends. Two command codes add 4 to the stored address after a successful transfer, so that sequential words can be moved without reloading the address. A cycle counter ends any transfer whose AXI handshakes stall for too long. An external interrupt input can also raise an event. A single output flag is high while any event bit is set.

The transfer sequencer has five states. ENG_IDLE waits for a launch. It goes to ENG_WR_REQ for a write command and to ENG_RD_REQ for a read command. ENG_WR_REQ presents the address and write channels until both have handshaken, then moves to ENG_WR_RESP. ENG_WR_RESP accepts the write response and returns to ENG_IDLE. ENG_RD_REQ presents the read address and, after its handshake, moves to ENG_RD_RESP. ENG_RD_RESP accepts the read data and returns to ENG_IDLE. From any non-idle state, an expired handshake timer returns the sequencer to ENG_IDLE with a timeout outcome.

Top module: `hbus_axil_bridge`

## Requirements
- R1: After reset the status register (index 0) reads 0x0020: only the initialised bit 5 is set. The control register (index 1) and the address registers (indices 2, 3) read 0, and `irq_flag` is low.
- R2: Writing command 0x8 into control bits 3:0 issues one AXI write. The address is {index 3, index 2}, the data is {index 5, index 4} and wstrb is 0xF. An OKAY response sets status bit 14 when control bit 14 is set.
- R3: Command 0xA issues one AXI read at {index 3, index 2}. An OKAY response stores the data so that index 6 returns bits 15:0 and index 7 returns bits 31:16. It sets status bit 15 (when control bit 15 is set) and the data-available bit 7.
- R4: Status bit 7 stays set when index 6 is read and clears when the host reads index 7.
- R5: Writing 1 to a status bit in 15:11 clears it. Writing 0 leaves it unchanged. Writes to bits 7, 6 and 5 have no effect.
- R6: Control bits 15:11 enable the status events 15:11 one for one. With an enable clear, the transfer still runs, but its event bit stays 0.
- R7: Commands 0x9 (write) and 0xB (read) add 4 to the 32-bit address after an OKAY response. A carry propagates from index 2 into index 3.
- R8: A SLVERR or DECERR response (resp bit 1 set) sets status bit 12 (error) instead of completion. It does not increment the address and does not set bit 7.
- R9: If no AXI handshake completes within TMO_CYCLES clock cycles, status bit 13 (timeout) is set, all valid outputs drop and the bridge becomes idle.
- R10: Status bit 6 (busy) is set from the cycle after a command is accepted until its outcome. A command written while busy starts no transfer.
- R11: A high `ext_irq` sets status bit 11 when control bit 11 is set. `irq_flag` is the OR of status bits 15:11.
- R12: Command 0x0 and the codes other than 0x8 to 0xB start no transfer and leave busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_wr | input | 1 | Host register write strobe |
| hb_rd | input | 1 | Host register read strobe (side effect on index 7 only) |
| hb_sel | input | 3 | Host register index 0..7 |
| hb_wdata | input | 16 | Host write data |
| hb_rdata | output | 16 | Host read data for the selected index |
| ext_irq | input | 1 | External interrupt event input |
| irq_flag | output | 1 | High while any status event bit is set |
| m_awaddr | output | 32 | AXI write address |
| m_awprot | output | 3 | AXI write protection, always 0 |
| m_awvalid | output | 1 | AXI write address valid |
| m_awready | input | 1 | AXI write address ready |
| m_wdata | output | 32 | AXI write data |
| m_wstrb | output | 4 | AXI write strobes, always 0xF |
| m_wvalid | output | 1 | AXI write data valid |
| m_wready | input | 1 | AXI write data ready |
| m_bresp | input | 2 | AXI write response code |
| m_bvalid | input | 1 | AXI write response valid |
| m_bready | output | 1 | AXI write response ready |
| m_araddr | output | 32 | AXI read address |
| m_arprot | output | 3 | AXI read protection, always 0 |
| m_arvalid | output | 1 | AXI read address valid |
| m_arready | input | 1 | AXI read address ready |
| m_rdata | input | 32 | AXI read data |
| m_rresp | input | 2 | AXI read response code |
| m_rvalid | input | 1 | AXI read data valid |
| m_rready | output | 1 | AXI read data ready |

## Verification
The hardest case to reach is a second command that arrives while a transfer is still in flight. With an always-ready subordinate, a transfer ends within two cycles of its launch, too fast for a host write to land inside it. The bench model therefore holds every ready and response low on request. It issues a write, reads busy and writes a read command while the write is parked, then releases the bus and confirms that only the first transfer ever appeared. The same stall, left in place, drives the handshake timer to expiry, and a response-code override reaches the error paths of both directions.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    localparam int HW = 16;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int EVN = 5;

    localparam logic [2:0] RI_STAT  = 3'd0;
    localparam logic [2:0] RI_CTRL  = 3'd1;
    localparam logic [2:0] RI_ADR_L = 3'd2;
    localparam logic [2:0] RI_ADR_H = 3'd3;
    localparam logic [2:0] RI_WD_L  = 3'd4;
    localparam logic [2:0] RI_WD_H  = 3'd5;
    localparam logic [2:0] RI_RD_L  = 3'd6;
    localparam logic [2:0] RI_RD_H  = 3'd7;

    localparam logic [3:0] OP_NOP    = 4'h0;
    localparam logic [3:0] OP_WR     = 4'h8;
    localparam logic [3:0] OP_WR_INC = 4'h9;
    localparam logic [3:0] OP_RD     = 4'hA;
    localparam logic [3:0] OP_RD_INC = 4'hB;

    // event vector positions (status/control bit = 11 + index)
    localparam int EV_IRQ = 0;
    localparam int EV_ERR = 1;
    localparam int EV_TMO = 2;
    localparam int EV_WR  = 3;
    localparam int EV_RD  = 4;

    typedef enum logic [2:0] {
        ENG_IDLE    = 3'd0,
        ENG_WR_REQ  = 3'd1,
        ENG_WR_RESP = 3'd2,
        ENG_RD_REQ  = 3'd3,
        ENG_RD_RESP = 3'd4
    } eng_state_e;

    typedef struct packed {
        logic ok;
        logic err;
        logic tmo;
        logic rd;
    } fin_t;

endpackage

// File: rtl/hbr_wdog.sv
module hbr_wdog #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expire = run && !kick && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || kick) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/hbr_xfer_engine.sv
module hbr_xfer_engine
    import hbr_pkg::*;
#(
    parameter int TMO_CYCLES = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_rd,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_wdata,
    output logic          busy,
    output fin_t          fin,
    output logic [DW-1:0] cap_data,
    output logic [AW-1:0] m_awaddr,
    output logic          m_awvalid,
    input  logic          m_awready,
    output logic [DW-1:0] m_wdata,
    output logic [DW/8-1:0] m_wstrb,
    output logic          m_wvalid,
    input  logic          m_wready,
    input  logic [1:0]    m_bresp,
    input  logic          m_bvalid,
    output logic          m_bready,
    output logic [AW-1:0] m_araddr,
    output logic          m_arvalid,
    input  logic          m_arready,
    input  logic [DW-1:0] m_rdata,
    input  logic [1:0]    m_rresp,
    input  logic          m_rvalid,
    output logic          m_rready
);

    eng_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          aw_done_q, w_done_q;
    logic          aw_hs, w_hs, b_hs, ar_hs, r_hs, any_hs;
    logic          expire;

    assign aw_hs  = m_awvalid && m_awready;
    assign w_hs   = m_wvalid && m_wready;
    assign b_hs   = m_bvalid && m_bready;
    assign ar_hs  = m_arvalid && m_arready;
    assign r_hs   = m_rvalid && m_rready;
    assign any_hs = aw_hs || w_hs || b_hs || ar_hs || r_hs;

    hbr_wdog #(.LIMIT(TMO_CYCLES)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .kick   (any_hs),
        .expire (expire)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outcome
    always_comb begin
        state_d = state_q;
        fin     = '0;
        unique case (state_q)
            ENG_IDLE: begin
                if (start) begin
                    state_d = start_rd ? ENG_RD_REQ : ENG_WR_REQ;
                end
            end
            ENG_WR_REQ: begin
                if ((aw_done_q || aw_hs) && (w_done_q || w_hs)) begin
                    state_d = ENG_WR_RESP;
                end else if (expire) begin
                    state_d = ENG_IDLE;
                    fin.tmo = 1'b1;
                end
            end
            ENG_WR_RESP: begin
                if (b_hs) begin
                    state_d = ENG_IDLE;
                    fin.err = m_bresp[1];
                    fin.ok  = !m_bresp[1];
                end else if (expire) begin
                    state_d = ENG_IDLE;
                    fin.tmo = 1'b1;
                end
            end
            ENG_RD_REQ: begin
                if (ar_hs) begin
                    state_d = ENG_RD_RESP;
                end else if (expire) begin
                    state_d = ENG_IDLE;
                    fin.tmo = 1'b1;
                end
            end
            ENG_RD_RESP: begin
                if (r_hs) begin
                    state_d = ENG_IDLE;
                    fin.err = m_rresp[1];
                    fin.ok  = !m_rresp[1];
                end else if (expire) begin
                    state_d = ENG_IDLE;
                    fin.tmo = 1'b1;
                end
            end
            default: state_d = ENG_IDLE;
        endcase
        fin.rd = (state_q == ENG_RD_REQ) || (state_q == ENG_RD_RESP);
    end

    // outputs
    always_comb begin
        busy      = (state_q != ENG_IDLE);
        m_awvalid = (state_q == ENG_WR_REQ) && !aw_done_q;
        m_wvalid  = (state_q == ENG_WR_REQ) && !w_done_q;
        m_bready  = (state_q == ENG_WR_RESP);
        m_arvalid = (state_q == ENG_RD_REQ);
        m_rready  = (state_q == ENG_RD_RESP);
        m_awaddr  = addr_q;
        m_araddr  = addr_q;
        m_wdata   = wdata_q;
        m_wstrb   = '1;
        cap_data  = m_rdata;
    end

    // transfer operands and channel progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            aw_done_q <= 1'b0;
            w_done_q  <= 1'b0;
        end else if (state_q == ENG_IDLE) begin
            aw_done_q <= 1'b0;
            w_done_q  <= 1'b0;
            if (start) begin
                addr_q  <= start_addr;
                wdata_q <= start_wdata;
            end
        end else if (state_q == ENG_WR_REQ) begin
            if (aw_hs) aw_done_q <= 1'b1;
            if (w_hs)  w_done_q  <= 1'b1;
        end
    end

    AST_AW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid && !m_awready && !expire |=> m_awvalid && $stable(m_awaddr)); // R2
    AST_AR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid && !m_arready && !expire |=> m_arvalid && $stable(m_araddr)); // R3
    AST_ONE_END: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fin.ok, fin.err, fin.tmo})); // R8
    AST_TMO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        fin.tmo |=> !m_awvalid && !m_wvalid && !m_arvalid && !busy); // R9
    AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_q) && $stable(wdata_q)); // R10

endmodule

// File: rtl/hbr_reg_bank.sv
module hbr_reg_bank
    import hbr_pkg::*;
#(
    parameter int ADDR_STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [2:0]    host_sel,
    input  logic [HW-1:0] host_wdata,
    output logic [HW-1:0] host_rdata,
    input  logic          irq_ext,
    output logic          irq_o,
    input  logic          busy,
    output logic          launch,
    output logic          launch_rd,
    output logic [AW-1:0] xfer_addr,
    output logic [DW-1:0] xfer_wdata,
    input  fin_t          fin,
    input  logic [DW-1:0] cap_data
);

    logic [EVN-1:0] ev_q, en_q, ev_set, ev_clr;
    logic [3:0]     cmd_q;
    logic [AW-1:0]  adr_q;
    logic [DW-1:0]  wd_q, rd_q;
    logic           inc_q, rd_avail_q, init_q;
    logic           ctrl_wr, stat_wr, cmd_ok, addr_wr, good_rd;

    assign ctrl_wr = host_wr && (host_sel == RI_CTRL);
    assign stat_wr = host_wr && (host_sel == RI_STAT);
    assign addr_wr = host_wr && ((host_sel == RI_ADR_L) || (host_sel == RI_ADR_H));
    assign cmd_ok  = (host_wdata[3:0] == OP_WR) || (host_wdata[3:0] == OP_WR_INC) ||
                     (host_wdata[3:0] == OP_RD) || (host_wdata[3:0] == OP_RD_INC);
    assign launch    = ctrl_wr && cmd_ok && !busy;
    assign launch_rd = host_wdata[1];
    assign good_rd   = fin.ok && fin.rd;

    assign xfer_addr  = adr_q;
    assign xfer_wdata = wd_q;

    always_comb begin
        ev_set         = '0;
        ev_set[EV_RD]  = good_rd;
        ev_set[EV_WR]  = fin.ok && !fin.rd;
        ev_set[EV_TMO] = fin.tmo;
        ev_set[EV_ERR] = fin.err;
        ev_set[EV_IRQ] = irq_ext;
        ev_set         = ev_set & en_q;
        ev_clr         = stat_wr ? host_wdata[HW-1 -: EVN] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q       <= '0;
            en_q       <= '0;
            cmd_q      <= OP_NOP;
            adr_q      <= '0;
            wd_q       <= '0;
            rd_q       <= '0;
            inc_q      <= 1'b0;
            rd_avail_q <= 1'b0;
            init_q     <= 1'b0;
        end else begin
            init_q <= 1'b1;
            ev_q   <= (ev_q & ~ev_clr) | ev_set;
            if (ctrl_wr) begin
                en_q  <= host_wdata[HW-1 -: EVN];
                cmd_q <= host_wdata[3:0];
            end
            if (launch) begin
                inc_q <= host_wdata[0];
            end
            if (fin.ok && inc_q) begin
                adr_q <= adr_q + AW'(ADDR_STEP);
            end
            if (host_wr && host_sel == RI_ADR_L) adr_q[HW-1:0]  <= host_wdata;
            if (host_wr && host_sel == RI_ADR_H) adr_q[AW-1:HW] <= host_wdata;
            if (host_wr && host_sel == RI_WD_L)  wd_q[HW-1:0]   <= host_wdata;
            if (host_wr && host_sel == RI_WD_H)  wd_q[DW-1:HW]  <= host_wdata;
            if (good_rd) begin
                rd_q <= cap_data;
            end
            if (good_rd) begin
                rd_avail_q <= 1'b1;
            end else if (host_rd && host_sel == RI_RD_H) begin
                rd_avail_q <= 1'b0;
            end
        end
    end

    assign irq_o = |ev_q;

    always_comb begin
        unique case (host_sel)
            RI_STAT:  host_rdata = {ev_q, 3'b000, rd_avail_q, busy, init_q, 5'b00000};
            RI_CTRL:  host_rdata = {en_q, 7'b0000000, cmd_q};
            RI_ADR_L: host_rdata = adr_q[HW-1:0];
            RI_ADR_H: host_rdata = adr_q[AW-1:HW];
            RI_WD_L:  host_rdata = wd_q[HW-1:0];
            RI_WD_H:  host_rdata = wd_q[DW-1:HW];
            RI_RD_L:  host_rdata = rd_q[HW-1:0];
            RI_RD_H:  host_rdata = rd_q[DW-1:HW];
            default:  host_rdata = '0;
        endcase
    end

    AST_STEP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        fin.ok && inc_q && !addr_wr |=> adr_q == $past(adr_q) + AW'(ADDR_STEP)); // R7
    AST_ERR_NOSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fin.err || fin.tmo) && !addr_wr |=> $stable(adr_q)); // R8
    AST_RDAV_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_avail_q) |-> $past(good_rd)); // R3
    AST_INIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        init_q |=> init_q); // R1

endmodule

// File: rtl/hbus_axil_bridge.sv
module hbus_axil_bridge
    import hbr_pkg::*;
#(
    parameter int TMO_CYCLES = 1024,
    parameter int ADDR_STEP  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hb_wr,
    input  logic        hb_rd,
    input  logic [2:0]  hb_sel,
    input  logic [15:0] hb_wdata,
    output logic [15:0] hb_rdata,
    input  logic        ext_irq,
    output logic        irq_flag,
    output logic [31:0] m_awaddr,
    output logic [2:0]  m_awprot,
    output logic        m_awvalid,
    input  logic        m_awready,
    output logic [31:0] m_wdata,
    output logic [3:0]  m_wstrb,
    output logic        m_wvalid,
    input  logic        m_wready,
    input  logic [1:0]  m_bresp,
    input  logic        m_bvalid,
    output logic        m_bready,
    output logic [31:0] m_araddr,
    output logic [2:0]  m_arprot,
    output logic        m_arvalid,
    input  logic        m_arready,
    input  logic [31:0] m_rdata,
    input  logic [1:0]  m_rresp,
    input  logic        m_rvalid,
    output logic        m_rready
);

    logic          busy, launch, launch_rd;
    logic [AW-1:0] xfer_addr;
    logic [DW-1:0] xfer_wdata, cap_data;
    fin_t          fin;

    assign m_awprot = 3'b000;
    assign m_arprot = 3'b000;

    hbr_reg_bank #(.ADDR_STEP(ADDR_STEP)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (hb_wr),
        .host_rd    (hb_rd),
        .host_sel   (hb_sel),
        .host_wdata (hb_wdata),
        .host_rdata (hb_rdata),
        .irq_ext    (ext_irq),
        .irq_o      (irq_flag),
        .busy       (busy),
        .launch     (launch),
        .launch_rd  (launch_rd),
        .xfer_addr  (xfer_addr),
        .xfer_wdata (xfer_wdata),
        .fin        (fin),
        .cap_data   (cap_data)
    );

    hbr_xfer_engine #(.TMO_CYCLES(TMO_CYCLES)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (launch),
        .start_rd    (launch_rd),
        .start_addr  (xfer_addr),
        .start_wdata (xfer_wdata),
        .busy        (busy),
        .fin         (fin),
        .cap_data    (cap_data),
        .m_awaddr    (m_awaddr),
        .m_awvalid   (m_awvalid),
        .m_awready   (m_awready),
        .m_wdata     (m_wdata),
        .m_wstrb     (m_wstrb),
        .m_wvalid    (m_wvalid),
        .m_wready    (m_wready),
        .m_bresp     (m_bresp),
        .m_bvalid    (m_bvalid),
        .m_bready    (m_bready),
        .m_araddr    (m_araddr),
        .m_arvalid   (m_arvalid),
        .m_arready   (m_arready),
        .m_rdata     (m_rdata),
        .m_rresp     (m_rresp),
        .m_rvalid    (m_rvalid),
        .m_rready    (m_rready)
    );

endmodule

// File: tb/hbus_axil_bridge_test.sv
module hbus_axil_bridge_test;

    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hb_wr = 1'b0, hb_rd = 1'b0;
    logic [2:0]  hb_sel = 3'd0;
    logic [15:0] hb_wdata = 16'h0;
    logic [15:0] hb_rdata;
    logic        ext_irq = 1'b0;
    logic        irq_flag;
    logic [31:0] m_awaddr, m_wdata, m_araddr;
    logic [31:0] m_rdata = 32'h0;
    logic [2:0]  m_awprot, m_arprot;
    logic [3:0]  m_wstrb;
    logic        m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
    logic        m_awready = 1'b0, m_wready = 1'b0, m_arready = 1'b0;
    logic        m_bvalid = 1'b0, m_rvalid = 1'b0;
    logic [1:0]  m_bresp = 2'b00, m_rresp = 2'b00;

    always #10 clk = ~clk;

    hbus_axil_bridge #(.TMO_CYCLES(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_sel(hb_sel),
        .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .ext_irq(ext_irq), .irq_flag(irq_flag),
        .m_awaddr(m_awaddr), .m_awprot(m_awprot), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
        .m_araddr(m_araddr), .m_arprot(m_arprot), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
    );

    int checks = 0;
    int errors = 0;
    int seen = 0;
    logic        stall = 1'b0;
    logic [1:0]  resp_mode = 2'b00;
    logic [31:0] mem [16];

    typedef struct {
        bit          wr;
        logic [31:0] addr;
        logic [31:0] data;
    } exp_t;
    exp_t exp_q[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic host_wr(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        hb_sel = sel; hb_wdata = d; hb_wr = 1'b1;
        @(negedge clk);
        hb_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] sel, output logic [15:0] d);
        @(negedge clk);
        hb_sel = sel; hb_rd = 1'b1;
        #5 d = hb_rdata;
        @(negedge clk);
        hb_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 60; i++) begin
            host_rd(3'd0, s);
            if (!s[6]) break;
        end
    endtask

    task automatic set_addr(input logic [31:0] a);
        host_wr(3'd2, a[15:0]);
        host_wr(3'd3, a[31:16]);
    endtask

    // driver: queue the expected transfer, then issue the command
    task automatic issue(input logic [15:0] ctrl, input bit push, input bit wr,
                         input logic [31:0] a, input logic [31:0] d);
        exp_t e;
        if (push) begin
            e.wr = wr; e.addr = a; e.data = d;
            exp_q.push_back(e);
        end
        host_wr(3'd1, ctrl);
    endtask

    // subordinate model and scoreboard monitor
    initial begin
        logic        aw_got, w_got, ar_got, b_hs, r_hs;
        logic [31:0] aw_a, w_d, ar_a;
        logic [3:0]  w_s;
        exp_t        e;
        aw_got = 0; w_got = 0; ar_got = 0; b_hs = 0; r_hs = 0;
        aw_a = 0; w_d = 0; ar_a = 0; w_s = 0;
        forever begin
            @(negedge clk);
            if (b_hs) begin m_bvalid = 1'b0; b_hs = 1'b0; end
            if (r_hs) begin m_rvalid = 1'b0; r_hs = 1'b0; end
            if (aw_got && w_got && !m_bvalid) begin
                m_bvalid = 1'b1; m_bresp = resp_mode;
                if (!resp_mode[1]) mem[aw_a[5:2]] = w_d;
                aw_got = 1'b0; w_got = 1'b0;
            end
            if (ar_got && !m_rvalid) begin
                m_rvalid = 1'b1; m_rresp = resp_mode; m_rdata = mem[ar_a[5:2]];
                ar_got = 1'b0;
            end
            if (stall) begin
                m_awready = 1'b0; m_wready = 1'b0; m_arready = 1'b0;
            end else begin
                m_awready = m_awvalid; m_wready = m_wvalid; m_arready = m_arvalid;
                if (m_awvalid) begin aw_got = 1'b1; aw_a = m_awaddr; end
                if (m_wvalid)  begin w_got = 1'b1; w_d = m_wdata; w_s = m_wstrb; end
                if (m_awvalid || m_wvalid) begin
                    if (aw_got && w_got) begin
                        seen++;
                        if (exp_q.size() == 0) check("R10 unexpected write", 32'd1, 32'd0);
                        else begin
                            e = exp_q.pop_front();
                            check("R2 kind", {31'd0, e.wr}, 32'd1);
                            check("R2 awaddr", aw_a, e.addr);
                            check("R2 wdata", w_d, e.data);
                            check("R2 wstrb", {28'd0, w_s}, 32'hF);
                        end
                    end
                end
                if (m_arvalid) begin
                    ar_got = 1'b1; ar_a = m_araddr; seen++;
                    if (exp_q.size() == 0) check("R10 unexpected read", 32'd1, 32'd0);
                    else begin
                        e = exp_q.pop_front();
                        check("R3 kind", {31'd0, e.wr}, 32'd0);
                        check("R3 araddr", ar_a, e.addr);
                    end
                end
                if (m_bvalid && m_bready) b_hs = 1'b1;
                if (m_rvalid && m_rready) r_hs = 1'b1;
            end
        end
    end

    bit done = 0;
    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int          base;
        for (int i = 0; i < 16; i++) mem[i] = 32'hA0B0C0D0 ^ (i * 32'h01030507);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        host_rd(3'd0, v); check("R1 status", {16'd0, v}, 32'h0020);
        host_rd(3'd1, v); check("R1 ctrl", {16'd0, v}, 32'h0);
        host_rd(3'd2, v); check("R1 addr low", {16'd0, v}, 32'h0);
        host_rd(3'd3, v); check("R1 addr high", {16'd0, v}, 32'h0);
        check("R1 irq_flag", {31'd0, irq_flag}, 32'd0);

        // R2 write
        set_addr(32'h1234_5670);
        host_wr(3'd4, 16'hBEEF); host_wr(3'd5, 16'hDEAD);
        issue(16'hF808, 1, 1, 32'h1234_5670, 32'hDEAD_BEEF);
        wait_idle();
        host_rd(3'd0, v); check("R2 write complete", {16'd0, v}, 32'h4020);
        check("R11 irq_flag on event", {31'd0, irq_flag}, 32'd1);

        // R5 write-one-to-clear
        host_wr(3'd0, 16'h0000);
        host_rd(3'd0, v); check("R5 zero write keeps", {16'd0, v}, 32'h4020);
        host_wr(3'd0, 16'h00E0);
        host_rd(3'd0, v); check("R5 read-only bits", {16'd0, v}, 32'h4020);
        host_wr(3'd0, 16'h4000);
        host_rd(3'd0, v); check("R5 clear", {16'd0, v}, 32'h0020);
        check("R11 irq_flag clear", {31'd0, irq_flag}, 32'd0);

        // R3 / R4 read
        set_addr(32'h0000_0008);
        issue(16'hF80A, 1, 0, 32'h0000_0008, 32'h0);
        wait_idle();
        host_rd(3'd0, v); check("R3 read complete", {16'd0, v}, 32'h80A0);
        host_rd(3'd6, v); check("R3 data low", {16'd0, v}, {16'd0, mem[2][15:0]});
        host_rd(3'd0, v); check("R4 avail after low", {16'd0, v & 16'h0080}, 32'h0080);
        host_rd(3'd7, v); check("R3 data high", {16'd0, v}, {16'd0, mem[2][31:16]});
        host_rd(3'd0, v); check("R4 avail cleared", {16'd0, v}, 32'h8020);
        host_wr(3'd0, 16'h8000);

        // R7 post-increment with carry
        set_addr(32'h0000_FFFC);
        host_wr(3'd4, 16'h2222); host_wr(3'd5, 16'h1111);
        issue(16'hF809, 1, 1, 32'h0000_FFFC, 32'h1111_2222);
        wait_idle();
        host_rd(3'd2, v); check("R7 addr low", {16'd0, v}, 32'h0000);
        host_rd(3'd3, v); check("R7 addr high", {16'd0, v}, 32'h0001);
        host_wr(3'd0, 16'hF800);
        issue(16'hF80B, 1, 0, 32'h0001_0000, 32'h0);
        wait_idle();
        host_rd(3'd2, v); check("R7 read inc", {16'd0, v}, 32'h0004);
        host_rd(3'd7, v); check("R7 read data", {16'd0, v}, {16'd0, mem[0][31:16]});
        host_wr(3'd0, 16'hF800);

        // R6 enables clear
        set_addr(32'h0000_0020);
        issue(16'h0008, 1, 1, 32'h0000_0020, 32'h1111_2222);
        wait_idle();
        host_rd(3'd0, v); check("R6 no event", {16'd0, v}, 32'h0020);
        check("R6 irq_flag", {31'd0, irq_flag}, 32'd0);

        // R8 error responses
        resp_mode = 2'b10;
        set_addr(32'h0000_0040);
        issue(16'hF809, 1, 1, 32'h0000_0040, 32'h1111_2222);
        wait_idle();
        host_rd(3'd0, v); check("R8 write error", {16'd0, v}, 32'h1020);
        host_rd(3'd2, v); check("R8 no increment", {16'd0, v}, 32'h0040);
        host_wr(3'd0, 16'hF800);
        resp_mode = 2'b11;
        issue(16'hF80B, 1, 0, 32'h0000_0040, 32'h0);
        wait_idle();
        host_rd(3'd0, v); check("R8 read error", {16'd0, v}, 32'h1020);
        host_rd(3'd2, v); check("R8 read no increment", {16'd0, v}, 32'h0040);
        host_wr(3'd0, 16'hF800);
        resp_mode = 2'b00;

        // R9 timeout
        base = seen;
        stall = 1'b1;
        set_addr(32'h0000_0080);
        issue(16'hF808, 0, 1, 32'h0, 32'h0);
        host_rd(3'd0, v); check("R10 busy set", {16'd0, v}, 32'h0060);
        repeat (TMO + 4) @(negedge clk);
        host_rd(3'd0, v); check("R9 timeout event", {16'd0, v}, 32'h2020);
        check("R9 valids dropped", {30'd0, m_awvalid, m_wvalid}, 32'd0);
        stall = 1'b0;
        host_wr(3'd0, 16'hF800);
        repeat (3) @(negedge clk);
        check("R9 no transfer seen", seen - base, 32'd0);

        // R10 command while busy ignored
        base = seen;
        stall = 1'b1;
        set_addr(32'h0000_0100);
        issue(16'hF808, 1, 1, 32'h0000_0100, 32'h1111_2222);
        host_wr(3'd1, 16'hF80A);
        host_rd(3'd0, v); check("R10 still busy", {16'd0, v}, 32'h0060);
        stall = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        host_rd(3'd0, v); check("R10 first completes", {16'd0, v}, 32'h4020);
        check("R10 single transfer", seen - base, 32'd1);
        host_wr(3'd0, 16'hF800);

        // R11 external interrupt
        host_wr(3'd1, 16'hF800);
        @(negedge clk); ext_irq = 1'b1;
        @(negedge clk); ext_irq = 1'b0;
        host_rd(3'd0, v); check("R11 irq event", {16'd0, v}, 32'h0820);
        check("R11 irq_flag high", {31'd0, irq_flag}, 32'd1);
        host_wr(3'd0, 16'h0800);
        host_wr(3'd1, 16'h0000);
        @(negedge clk); ext_irq = 1'b1;
        @(negedge clk); ext_irq = 1'b0;
        host_rd(3'd0, v); check("R11 irq disabled", {16'd0, v}, 32'h0020);

        // R12 NOP and undefined codes
        base = seen;
        host_wr(3'd1, 16'hF805);
        host_rd(3'd0, v); check("R12 undefined no busy", {16'd0, v}, 32'h0020);
        host_wr(3'd1, 16'hF800);
        host_rd(3'd0, v); check("R12 nop no busy", {16'd0, v}, 32'h0020);
        repeat (4) @(negedge clk);
        check("R12 no transfer", seen - base, 32'd0);
        check("R10 scoreboard drained", exp_q.size(), 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule